// File: doc/BRIEF.md
# Decision-Directed Digital Timing Loop

This block closes the timing loop of a read channel whose converter runs on a fixed clock slightly faster than the symbol rate. The loop runs once per converter sample. When a synchronized sample and its detector decision are presented, it forms a decision-directed timing error from the current and previous sample/decision pairs. The decision arrives a fixed number of symbols after its sample, so samples are delayed internally to line up with their decisions. The error drives a second-order loop: a saturating frequency integrator, and a proportional term. Both are added to a fixed nominal advance that covers the oversampling.

The phase accumulator holds a fraction of one converter sample period. On every converter sample it advances by the clamped step. When it passes a whole period it flags a skip: that converter sample yields no output symbol. The top six bits of the phase go to the interpolator as its quantized fractional sampling point. A start-of-sector pulse empties the loop and loads an initial phase. Once a preamble of known length has been received, the loop switches from wide acquisition gains to narrow tracking gains. Gains are power-of-two right shifts.

Top module: `tr_timing_loop`

## Requirements
- R1: After reset, `phase_frac`, `skip`, `out_vld` and `tracking` are all 0, and the frequency integrator, the sample history and the symbol counter are zero.
- R2: A cycle with `sos` high clears the integrator, sample history and symbol counter, and loads the phase accumulator with `init_phase` in its top six bits and zeros below. On the next cycle, `phase_frac` equals that `init_phase`, and `skip`, `out_vld` and `tracking` are 0. `sos` takes priority over every other input.
- R3: On each cycle with `smp_vld` high, the PH_W-bit phase advances modulo 2^PH_W by the step NOM_STEP + theta + a. Here theta is the integrator value after this cycle's update, and a is the proportional term (0 when no error is formed). `phase_frac` is phase bits [PH_W-1:PH_W-6], registered.
- R4: For each cycle with `smp_vld` high, exactly one of `skip` and `out_vld` is high on the next cycle. `skip` is high when the advance carried past 2^PH_W.
- R5: A cycle with `smp_vld` low leaves the phase unchanged, and gives `skip` = `out_vld` = 0 on the next cycle.
- R6: A symbol is accepted when `smp_vld` and `sym_vld` are both high. For accepted symbol k, the error is e = ya_k·d_(k-1) − ya_(k-1)·d_k, where d is `sym_d` and ya_k is the `sym_y` accepted DEC_LAT symbols earlier.
- R7: After `sos`, the first DEC_LAT+1 accepted symbols form no error, so they leave theta and the proportional term unchanged.
- R8: `sym_vld` with `smp_vld` low has no effect: nothing enters the history, the integrator or the symbol count.
- R9: After `sos`, accepted symbols 0 to PRE_LEN−1 use the shifts ACQ_A_SH/ACQ_B_SH, and later symbols use TRK_A_SH/TRK_B_SH. `tracking` rises on the cycle after the PRE_LEN-th accepted symbol and stays high until the next `sos`.
- R10: theta += (e·2^E_LSH) >>> B_SH, with a = (e·2^E_LSH) >>> A_SH (arithmetic shifts). theta saturates at −2^(TH_W−1) and 2^(TH_W−1)−1 instead of wrapping.
- R11: The step is clamped to [0, 2^PH_W−1]. A negative step leaves the phase where it is, and the phase can never carry more than once per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sos | input | 1 | Start-of-sector pulse |
| init_phase | input | 6 | Initial phase loaded on `sos` |
| smp_vld | input | 1 | A converter sample is present this cycle |
| sym_vld | input | 1 | `sym_y`/`sym_d` carry a symbol |
| sym_y | input | W_Y | Synchronized sample, signed |
| sym_d | input | W_D | Detector decision, signed, DEC_LAT symbols late |
| phase_frac | output | 6 | Quantized fractional sampling phase |
| skip | output | 1 | Last sample produced no symbol |
| out_vld | output | 1 | Last sample produced a symbol |
| tracking | output | 1 | Tracking gains in use |

## Verification
The bench builds the block with PRE_LEN set to 16 and every other parameter at its default. This brings the acquisition-to-tracking handover within a few dozen symbols, so both gain pairs meet a long random symbol stream in one run. With the default 16-bit integrator and a full-scale aligned error pattern, theta reaches either rail in about ten symbols. That puts the step clamp at both ends, and the error gating right after `sos`, in reach of a short sector.

// File: rtl/tr_pkg.sv
package tr_pkg;
    localparam int FRAC_W = 6;

    typedef struct packed {
        logic [5:0] a_sh;
        logic [5:0] b_sh;
    } gain_t;
endpackage

// File: rtl/tr_ted.sv
module tr_ted #(
    parameter int W_Y     = 8,
    parameter int W_D     = 4,
    parameter int DEC_LAT = 4,
    parameter int W_E     = W_Y + W_D + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  acc,
    input  logic signed [W_Y-1:0] y,
    input  logic signed [W_D-1:0] d,
    output logic signed [W_E-1:0] e,
    output logic                  e_vld
);
    localparam int FW = $clog2(DEC_LAT + 2);
    localparam logic [FW-1:0] FULL = FW'(DEC_LAT + 1);

    typedef struct packed {
        logic [DEC_LAT-1:0][W_Y-1:0] hist;
        logic signed [W_Y-1:0]       yap;
        logic signed [W_D-1:0]       dp;
        logic [FW-1:0]               fill;
    } st_t;

    st_t q, n;
    logic signed [W_Y-1:0] ya;
    logic signed [W_E-1:0] p_cur, p_old;

    always_comb begin
        n     = q;
        ya    = q.hist[DEC_LAT-1];
        p_cur = W_E'(ya) * W_E'(q.dp);
        p_old = W_E'(q.yap) * W_E'(d);
        e     = p_cur - p_old;
        e_vld = acc && (q.fill == FULL);
        if (clr) begin
            n = '0;
        end else if (acc) begin
            n.hist[0] = y;
            for (int i = 1; i < DEC_LAT; i++) begin
                n.hist[i] = q.hist[i-1];
            end
            n.yap = ya;
            n.dp  = d;
            if (q.fill != FULL) n.fill = q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R7: no error straight after a clear
    a_r7_gate_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !e_vld);
    // R8: history frozen while no symbol is accepted
    a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(q.hist));
endmodule

// File: rtl/tr_loop_filter.sv
module tr_loop_filter #(
    parameter int W_E      = 13,
    parameter int TH_W     = 16,
    parameter int PH_W     = 16,
    parameter int E_LSH    = 9,
    parameter int NOM_STEP = 3277,
    parameter int ACQ_A_SH = 3,
    parameter int ACQ_B_SH = 8,
    parameter int TRK_A_SH = 6,
    parameter int TRK_B_SH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  upd,
    input  logic                  track,
    input  logic signed [W_E-1:0] e,
    output logic [PH_W-1:0]       step
);
    localparam int W_X = W_E + E_LSH + TH_W + PH_W + 2;
    localparam tr_pkg::gain_t ACQ = '{a_sh: 6'(ACQ_A_SH), b_sh: 6'(ACQ_B_SH)};
    localparam tr_pkg::gain_t TRK = '{a_sh: 6'(TRK_A_SH), b_sh: 6'(TRK_B_SH)};
    localparam logic signed [W_X-1:0] TH_MAX =
        {{(W_X-TH_W+1){1'b0}}, {(TH_W-1){1'b1}}};
    localparam logic signed [W_X-1:0] TH_MIN =
        {{(W_X-TH_W+1){1'b1}}, {(TH_W-1){1'b0}}};
    localparam logic signed [W_X-1:0] STEP_MAX =
        {{(W_X-PH_W){1'b0}}, {PH_W{1'b1}}};
    localparam logic signed [W_X-1:0] NOM_X = W_X'(NOM_STEP);

    typedef struct packed {
        logic signed [TH_W-1:0] theta;
    } st_t;

    st_t q, n;
    tr_pkg::gain_t g;
    logic signed [W_X-1:0] e_ext, ex, a_term, b_term, th_sum, th_new, raw;

    always_comb begin
        n      = q;
        g      = track ? TRK : ACQ;
        e_ext  = {{(W_X-W_E){e[W_E-1]}}, e};
        ex     = e_ext <<< E_LSH;
        a_term = ex >>> g.a_sh;
        b_term = ex >>> g.b_sh;
        th_sum = {{(W_X-TH_W){q.theta[TH_W-1]}}, q.theta} + b_term;
        if (clr) begin
            n.theta = '0;
        end else if (upd) begin
            if (th_sum > TH_MAX)      n.theta = TH_MAX[TH_W-1:0];
            else if (th_sum < TH_MIN) n.theta = TH_MIN[TH_W-1:0];
            else                      n.theta = th_sum[TH_W-1:0];
        end
        th_new = {{(W_X-TH_W){n.theta[TH_W-1]}}, n.theta};
        raw    = NOM_X + th_new + ((upd && !clr) ? a_term : '0);
        if (raw < 0)             step = '0;
        else if (raw > STEP_MAX) step = STEP_MAX[PH_W-1:0];
        else                     step = raw[PH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R10: upper rail holds under further positive error
    a_r10_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (q.theta == TH_MAX[TH_W-1:0] && upd && !clr && e > 0)
        |=> q.theta == TH_MAX[TH_W-1:0]);
    // R10: lower rail holds under further negative error
    a_r10_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (q.theta == TH_MIN[TH_W-1:0] && upd && !clr && e < 0)
        |=> q.theta == TH_MIN[TH_W-1:0]);
    // R2: integrator emptied by start of sector
    a_r2_theta_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q.theta == '0);
    // R7: integrator only moves on a formed error
    a_r7_theta_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(q.theta));
endmodule

// File: rtl/tr_phase_acc.sv
module tr_phase_acc #(
    parameter int PH_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic [tr_pkg::FRAC_W-1:0] init,
    input  logic                      smp,
    input  logic [PH_W-1:0]           step,
    output logic [tr_pkg::FRAC_W-1:0] frac,
    output logic                      skip,
    output logic                      out_vld
);
    localparam int FW = tr_pkg::FRAC_W;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            skip;
        logic            ovld;
    } st_t;

    st_t q, n;
    logic [PH_W:0] sum;

    always_comb begin
        n   = q;
        sum = {1'b0, q.phase} + {1'b0, step};
        if (clr) begin
            n.phase = {init, {(PH_W-FW){1'b0}}};
            n.skip  = 1'b0;
            n.ovld  = 1'b0;
        end else if (smp) begin
            n.phase = sum[PH_W-1:0];
            n.skip  = sum[PH_W];
            n.ovld  = !sum[PH_W];
        end else begin
            n.skip  = 1'b0;
            n.ovld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign frac    = q.phase[PH_W-1 -: FW];
    assign skip    = q.skip;
    assign out_vld = q.ovld;

    // R4: skip and a valid symbol never together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip && out_vld));
    // R4: every sample gives exactly one of the two
    a_r4_one_each: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr) |=> (skip ^ out_vld));
    // R5: no sample, no motion
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp && !clr) |=> ($stable(q.phase) && !skip && !out_vld));
    // R11: zero step keeps phase and yields a symbol
    a_r11_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr && step == '0) |=> ($stable(q.phase) && out_vld));
endmodule

// File: rtl/tr_timing_loop.sv
module tr_timing_loop #(
    parameter int W_Y      = 8,
    parameter int W_D      = 4,
    parameter int DEC_LAT  = 4,
    parameter int PH_W     = 16,
    parameter int TH_W     = 16,
    parameter int E_LSH    = 9,
    parameter int NOM_STEP = 3277,
    parameter int PRE_LEN  = 128,
    parameter int ACQ_A_SH = 3,
    parameter int ACQ_B_SH = 8,
    parameter int TRK_A_SH = 6,
    parameter int TRK_B_SH = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sos,
    input  logic [tr_pkg::FRAC_W-1:0] init_phase,
    input  logic                      smp_vld,
    input  logic                      sym_vld,
    input  logic signed [W_Y-1:0]     sym_y,
    input  logic signed [W_D-1:0]     sym_d,
    output logic [tr_pkg::FRAC_W-1:0] phase_frac,
    output logic                      skip,
    output logic                      out_vld,
    output logic                      tracking
);
    localparam int W_E = W_Y + W_D + 1;
    localparam int CW  = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] PRE_END = CW'(PRE_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t q, n;
    logic acc, e_vld;
    logic signed [W_E-1:0] e;
    logic [PH_W-1:0] step;

    always_comb begin
        n   = q;
        acc = smp_vld && sym_vld && !sos;
        if (sos)                       n.cnt = '0;
        else if (acc && !tracking)     n.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tracking = (q.cnt == PRE_END);

    tr_ted #(.W_Y(W_Y), .W_D(W_D), .DEC_LAT(DEC_LAT), .W_E(W_E)) u_ted (
        .clk(clk), .rst_n(rst_n), .clr(sos), .acc(acc),
        .y(sym_y), .d(sym_d), .e(e), .e_vld(e_vld)
    );

    tr_loop_filter #(
        .W_E(W_E), .TH_W(TH_W), .PH_W(PH_W), .E_LSH(E_LSH),
        .NOM_STEP(NOM_STEP), .ACQ_A_SH(ACQ_A_SH), .ACQ_B_SH(ACQ_B_SH),
        .TRK_A_SH(TRK_A_SH), .TRK_B_SH(TRK_B_SH)
    ) u_lf (
        .clk(clk), .rst_n(rst_n), .clr(sos), .upd(e_vld),
        .track(tracking), .e(e), .step(step)
    );

    tr_phase_acc #(.PH_W(PH_W)) u_pa (
        .clk(clk), .rst_n(rst_n), .clr(sos), .init(init_phase),
        .smp(smp_vld), .step(step), .frac(phase_frac),
        .skip(skip), .out_vld(out_vld)
    );

    // R2: start of sector lands the initial phase
    a_r2_sos_load: assert property (@(posedge clk) disable iff (!rst_n)
        sos |=> (phase_frac == $past(init_phase) && !skip && !out_vld && !tracking));
    // R8: a symbol without a sample forms no error
    a_r8_sym_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && !smp_vld) |-> !e_vld);
    // R9: tracking persists until the next sector
    a_r9_track_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !sos) |=> tracking);
    // R9: tracking only starts after an accepted symbol
    a_r9_track_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tracking) |-> $past(acc));
endmodule

// File: tb/tr_timing_loop_tb.sv
module tr_timing_loop_tb;
    localparam int CLK_NS   = 10;
    localparam int W_Y      = 8;
    localparam int W_D      = 4;
    localparam int DEC_LAT  = 4;
    localparam int PH_W     = 16;
    localparam int TH_W     = 16;
    localparam int E_LSH    = 9;
    localparam int NOM_STEP = 3277;
    localparam int PRE_LEN  = 16;
    localparam int ACQ_A    = 3, ACQ_B = 8, TRK_A = 6, TRK_B = 12;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic rst_n, sos, smp_vld, sym_vld;
    logic [5:0] init_phase;
    logic signed [W_Y-1:0] sym_y;
    logic signed [W_D-1:0] sym_d;
    logic [5:0] phase_frac;
    logic skip, out_vld, tracking;

    tr_timing_loop #(.PRE_LEN(PRE_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .sos(sos), .init_phase(init_phase),
        .smp_vld(smp_vld), .sym_vld(sym_vld), .sym_y(sym_y), .sym_d(sym_d),
        .phase_frac(phase_frac), .skip(skip), .out_vld(out_vld),
        .tracking(tracking)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    longint m_phase, m_theta;
    int m_cnt, m_fill, m_yap, m_dp;
    int yq[$];
    bit m_skip, m_ovld;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        chk(req, "phase_frac", longint'(phase_frac), m_phase >> (PH_W-6));
        chk(req, "skip", longint'(skip), longint'(m_skip));
        chk(req, "out_vld", longint'(out_vld), longint'(m_ovld));
        chk("R9", "tracking", longint'(tracking), longint'(m_cnt == PRE_LEN));
    endtask

    task automatic model_clear(int ini);
        m_phase = longint'(ini) << (PH_W-6);
        m_theta = 0; m_cnt = 0; m_fill = 0; m_yap = 0; m_dp = 0;
        yq.delete();
        repeat (DEC_LAT) yq.push_back(0);
        m_skip = 0; m_ovld = 0;
    endtask

    task automatic model_step(bit s, bit sv, int y, int d, bit so, int ini);
        longint e, ex, a, st, sum;
        int ya, ash, bsh;
        bit acc, ev;
        if (so) begin
            model_clear(ini);
            return;
        end
        acc = s && sv;
        ev  = acc && (m_fill > DEC_LAT);
        a   = 0;
        ash = (m_cnt == PRE_LEN) ? TRK_A : ACQ_A;
        bsh = (m_cnt == PRE_LEN) ? TRK_B : ACQ_B;
        if (acc) begin
            ya = yq.pop_front();
            e  = longint'(ya) * m_dp - longint'(m_yap) * d;
            yq.push_back(y);
            m_yap = ya; m_dp = d;
            if (m_fill < DEC_LAT + 1) m_fill++;
            if (m_cnt < PRE_LEN) m_cnt++;
            if (ev) begin
                ex = e * (longint'(1) << E_LSH);
                m_theta = m_theta + (ex >>> bsh);
                if (m_theta > (longint'(1) << (TH_W-1)) - 1) m_theta = (longint'(1) << (TH_W-1)) - 1;
                if (m_theta < -(longint'(1) << (TH_W-1)))    m_theta = -(longint'(1) << (TH_W-1));
                a = ex >>> ash;
            end
        end
        if (s) begin
            st = NOM_STEP + m_theta + a;
            if (st < 0) st = 0;
            if (st > (longint'(1) << PH_W) - 1) st = (longint'(1) << PH_W) - 1;
            sum = m_phase + st;
            m_skip = (sum >= (longint'(1) << PH_W));
            m_ovld = !m_skip;
            m_phase = sum % (longint'(1) << PH_W);
        end else begin
            m_skip = 0; m_ovld = 0;
        end
    endtask

    task automatic cyc(string req, bit s, bit sv, int y, int d, bit so, int ini);
        smp_vld = s; sym_vld = sv; sym_y = W_Y'(y); sym_d = W_D'(d);
        sos = so; init_phase = 6'(ini);
        model_step(s, sv, y, d, so, ini);
        @(negedge clk);
        compare(req);
    endtask

    function automatic int sgn4(int k);
        return (((k % 4) + 4) % 4 < 2) ? 1 : -1;
    endfunction

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int skips;
        logic [5:0] held;
        rst_n = 0; sos = 0; smp_vld = 0; sym_vld = 0;
        sym_y = '0; sym_d = '0; init_phase = '0;
        model_clear(0);
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        cyc("R1", 0, 0, 0, 0, 0, 0);

        // R2: load initial phase
        cyc("R2", 0, 0, 0, 0, 1, 40);
        chk("R2", "frac after sos", longint'(phase_frac), 40);

        // R3/R4: free running with no symbols, nominal step only
        skips = 0;
        for (int i = 0; i < 80; i++) begin
            cyc("R3", 1, 0, 0, 0, 0, 0);
            skips += skip;
        end
        chk("R4", "skip count over 80 samples", skips, 4);

        // R5: no sample
        for (int i = 0; i < 5; i++) cyc("R5", 0, 0, 0, 0, 0, 0);

        // R7 then R9: first DEC_LAT+1 symbols form no error
        cyc("R2", 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) cyc("R7", 1, 1, 127, -7, 0, 0);
        chk("R7", "frac after gated symbols", longint'(phase_frac), 16);
        for (int i = 5; i < PRE_LEN; i++) begin
            cyc("R9", 1, 1, $urandom_range(0, 254) - 127, $urandom_range(0, 14) - 7, 0, 0);
            chk("R9", "tracking during preamble", longint'(tracking), longint'(i + 1 >= PRE_LEN));
        end

        // R6/R9: random symbols in tracking, with occasional missing symbols
        for (int i = 0; i < 300; i++) begin
            cyc("R6", 1, ($urandom_range(0, 19) != 0), $urandom_range(0, 254) - 127,
                $urandom_range(0, 14) - 7, 0, 0);
        end

        // R8: symbols without samples, then resume
        for (int i = 0; i < 20; i++) begin
            cyc("R8", (i % 3 == 0), 1, $urandom_range(0, 254) - 127,
                $urandom_range(0, 14) - 7, 0, 0);
        end
        for (int i = 0; i < 30; i++) begin
            cyc("R8", 1, 1, $urandom_range(0, 254) - 127, $urandom_range(0, 14) - 7, 0, 0);
        end

        // R6/R10: acquisition through a fresh sector with random symbols
        cyc("R2", 0, 0, 0, 0, 1, 21);
        for (int i = 0; i < 60; i++) begin
            cyc("R6", 1, 1, $urandom_range(0, 254) - 127, $urandom_range(0, 14) - 7, 0, 0);
        end

        // R10: drive theta to the positive rail, then zero error
        cyc("R2", 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 40; k++) cyc("R10", 1, 1, 127 * sgn4(k), 7 * sgn4(k - 3), 0, 0);
        for (int k = 0; k < 30; k++) cyc("R10", 1, 1, 0, 0, 0, 0);

        // R11: drive theta to the negative rail, step clamps to zero
        cyc("R2", 0, 0, 0, 0, 1, 33);
        for (int k = 0; k < 40; k++) cyc("R11", 1, 1, 127 * sgn4(k), -7 * sgn4(k - 3), 0, 0);
        for (int k = 0; k < 6; k++) cyc("R11", 1, 1, 0, 0, 0, 0);
        held = phase_frac;
        skips = 0;
        for (int k = 0; k < 10; k++) begin
            cyc("R11", 1, 1, 0, 0, 0, 0);
            skips += skip;
        end
        chk("R11", "phase held under negative step", longint'(phase_frac), longint'(held));
        chk("R11", "no skips under negative step", skips, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule